// File: doc/BRIEF.md
# Ring-Buffer Chained DMA Reader

This block is the source side of a DMA channel that walks a linked list of 128-bit tags held in a circular buffer in memory. The ring is given as a base address and a byte-size mask. Every tag address and every in-ring data address is formed as base plus the masked offset, so the list wraps around the ring. Each tag carries a packet type, a quadword count, an interrupt-request bit and an address field. The engine reads the tag, then streams the data quadwords of that packet, one at a time, to a consumer through a valid/ready output.

A producer fills the ring and reports each deposit as a strobe with a quadword count. The engine keeps these credits and spends one for every quadword it reads from the ring, tags included. When it needs a ring quadword and no credit is left, it stops, raises a single empty interrupt and shows a waiting flag. It resumes once the producer deposits more. When the chain ends, the engine drops its busy flag and pulses a done interrupt. Its next-tag pointer then shows where a later chain would continue.

Top module: `ring_chain_dma`

## Requirements
- R1: Every tag and in-ring data read uses address ring_base + (offset & ring_mask), and quadwords are 16 bytes apart. The tag after a packet lies in the ring, directly past the tag or past its data. The start address is wrapped in the same way.
- R2: A tag is the quadword read at the tag pointer. In bits 31:0 of that quadword, bits 30:28 give the packet type, bits 15:0 the quadword count and bit 31 the interrupt-request flag. Bits 63:32 hold the address field.
- R3: Type 1 (count) and types 2 to 6 send the count quadwords that directly follow the tag. The chain then continues with the tag after that data. A count of zero sends nothing.
- R4: Type 7 (end) sends the quadwords that follow the tag. next_tag_o becomes the ring position after that data, and the chain ends.
- R5: Type 0 (reference-end) reads its data from the address field, stepping by 16 bytes without wrap and without spending credit. next_tag_o becomes the slot after the tag, and the chain ends.
- R6: When tie_en_i is 1 and the tag's bit 31 is 1, the chain ends after that packet and early_end_o is set. When tie_en_i is 0, bit 31 has no effect.
- R7: avail_o grows by dep_qwc_i on each deposit strobe and drops by one for each ring quadword read. It never changes otherwise.
- R8: When a ring read is needed, avail_o is zero and no deposit arrives, the engine issues no read, sets waiting_o and pulses empty_irq_o once for the whole stall.
- R9: A deposit with a nonzero count clears waiting_o, and the transfer resumes.
- R10: At the end of a chain, busy_o falls and done_irq_o pulses for one cycle in that same cycle.
- R11: out_valid_o and out_data_o hold until out_ready_i is sampled high. Quadwords leave in packet order, one per handshake.
- R12: start_i is ignored while busy_o is 1. When idle, start_i loads the wrapped start address and clears early_end_o.
- R13: After reset, busy_o, out_valid_o, rd_req_o, waiting_o, both interrupts, early_end_o and avail_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a chain at first_tag_i |
| tie_en_i | input | 1 | Allow the tag interrupt bit to end the chain |
| ring_base_i | input | AW | Ring base byte address, aligned to the ring size |
| ring_mask_i | input | AW | Ring size in bytes minus one |
| first_tag_i | input | AW | Byte address of the first tag |
| dep_valid_i | input | 1 | Producer deposit strobe |
| dep_qwc_i | input | 16 | Quadwords deposited |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read byte address |
| rd_data_i | input | 128 | Read data, valid the cycle after the request |
| out_valid_o | output | 1 | Output quadword valid |
| out_ready_i | input | 1 | Consumer ready |
| out_data_o | output | 128 | Output quadword |
| empty_irq_o | output | 1 | Ring-empty interrupt pulse |
| done_irq_o | output | 1 | Chain-done interrupt pulse |
| busy_o | output | 1 | Channel running |
| early_end_o | output | 1 | Chain ended by a tag interrupt request |
| waiting_o | output | 1 | Stalled for producer credit |
| next_tag_o | output | AW | Current or next tag address |
| avail_o | output | AVW | Deposited quadwords not yet read |

## Verification
The chains used mix count, odd-type and end tags fully in credit. One chain starts near the top of the ring so that its data and its closing tag wrap past the base. One chain uses a reference tag whose data lies outside the ring with only one credit. One chain is starved both at its tag and in the middle of its data. Two chains use the tag interrupt bit, once enabled and once disabled. These cases separate wrap errors and wrong next-tag arithmetic from credit-accounting errors, and both from misdecoded packet types. Throughout, the consumer throttles ready in a fixed pattern, so ordering and hold errors show up on the data port.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    localparam int QWC_W    = 16;
    localparam int QW_BITS  = 128;
    localparam int QW_SHIFT = 4;

    localparam logic [2:0] KIND_REF_END = 3'd0;
    localparam logic [2:0] KIND_END     = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_TAG_RSP,
        ST_DATA,
        ST_DATA_RSP,
        ST_OUT
    } dma_state_e;

endpackage

// File: rtl/ring_dma_tag_dec.sv
module ring_dma_tag_dec
    import ring_dma_pkg::*;
(
    input  logic [QW_BITS-1:0] tag_i,
    output logic [QWC_W-1:0]   qwc_o,
    output logic               irq_o,
    output logic [31:0]        addr_o,
    output logic               is_ref_o,
    output logic               is_end_o
);
    logic [2:0] kind;
    logic       unused_bits;

    assign kind        = tag_i[30:28];
    assign qwc_o       = tag_i[QWC_W-1:0];
    assign irq_o       = tag_i[31];
    assign addr_o      = tag_i[63:32];
    assign is_ref_o    = (kind == KIND_REF_END);
    assign is_end_o    = (kind == KIND_END);
    assign unused_bits = ^{tag_i[QW_BITS-1:64], tag_i[27:QWC_W]};

endmodule

// File: rtl/ring_dma_credit.sv
module ring_dma_credit
    import ring_dma_pkg::*;
#(
    parameter int AVW = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dep_valid_i,
    input  logic [QWC_W-1:0] dep_qwc_i,
    input  logic             need_i,
    input  logic             take_i,
    output logic [AVW-1:0]   avail_o,
    output logic             zero_o,
    output logic             waiting_o,
    output logic             empty_irq_o
);
    typedef struct packed {
        logic [AVW-1:0] avail;
        logic           waiting;
        logic           irq;
    } credit_t;

    credit_t q, d;
    logic    dep_hit;
    logic    stall;

    always_comb begin
        d       = q;
        dep_hit = dep_valid_i && (dep_qwc_i != '0);
        stall   = need_i && (q.avail == '0);
        d.avail = q.avail
                + (dep_valid_i ? AVW'(dep_qwc_i) : '0)
                - (take_i ? AVW'(1) : '0);
        d.irq   = stall && !dep_hit && !q.waiting;
        if (dep_hit) begin
            d.waiting = 1'b0;
        end else if (stall) begin
            d.waiting = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign avail_o     = q.avail;
    assign zero_o      = (q.avail == '0);
    assign waiting_o   = q.waiting;
    assign empty_irq_o = q.irq;

endmodule

// File: rtl/ring_chain_dma.sv
module ring_chain_dma
    import ring_dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int AVW = 20
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               tie_en_i,
    input  logic [AW-1:0]      ring_base_i,
    input  logic [AW-1:0]      ring_mask_i,
    input  logic [AW-1:0]      first_tag_i,
    input  logic               dep_valid_i,
    input  logic [QWC_W-1:0]   dep_qwc_i,
    output logic               rd_req_o,
    output logic [AW-1:0]      rd_addr_o,
    input  logic [QW_BITS-1:0] rd_data_i,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [QW_BITS-1:0] out_data_o,
    output logic               empty_irq_o,
    output logic               done_irq_o,
    output logic               busy_o,
    output logic               early_end_o,
    output logic               waiting_o,
    output logic [AW-1:0]      next_tag_o,
    output logic [AVW-1:0]     avail_o
);
    localparam logic [AW-1:0] QW_STEP = AW'(1) << QW_SHIFT;

    typedef struct packed {
        dma_state_e          st;
        logic [AW-1:0]       tag_ptr;
        logic [AW-1:0]       data_ptr;
        logic [QWC_W-1:0]    remain;
        logic                in_ring;
        logic                last;
        logic                early;
        logic                busy;
        logic                done;
        logic                out_valid;
        logic [QW_BITS-1:0]  out_data;
    } engine_t;

    engine_t q, d;

    logic             need;
    logic             take;
    logic             avail_zero;
    logic [QWC_W-1:0] tag_qwc;
    logic             tag_irq;
    logic [31:0]      tag_addr;
    logic             tag_ref;
    logic             tag_end;
    logic [AW-1:0]    after_tag;
    logic [AW-1:0]    span;

    function automatic logic [AW-1:0] ring_wrap(input logic [AW-1:0] a,
                                                input logic [AW-1:0] base,
                                                input logic [AW-1:0] mask);
        return base + (a & mask);
    endfunction

    ring_dma_tag_dec i_dec (
        .tag_i    (rd_data_i),
        .qwc_o    (tag_qwc),
        .irq_o    (tag_irq),
        .addr_o   (tag_addr),
        .is_ref_o (tag_ref),
        .is_end_o (tag_end)
    );

    ring_dma_credit #(.AVW(AVW)) i_credit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dep_valid_i (dep_valid_i),
        .dep_qwc_i   (dep_qwc_i),
        .need_i      (need),
        .take_i      (take),
        .avail_o     (avail_o),
        .zero_o      (avail_zero),
        .waiting_o   (waiting_o),
        .empty_irq_o (empty_irq_o)
    );

    assign after_tag = ring_wrap(q.tag_ptr + QW_STEP, ring_base_i, ring_mask_i);
    assign span      = AW'(tag_qwc) << QW_SHIFT;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        need      = 1'b0;
        take      = 1'b0;
        rd_req_o  = 1'b0;
        rd_addr_o = q.tag_ptr;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.tag_ptr = ring_wrap(first_tag_i, ring_base_i, ring_mask_i);
                    d.busy    = 1'b1;
                    d.early   = 1'b0;
                    d.st      = ST_TAG;
                end
            end
            ST_TAG: begin
                need = 1'b1;
                if (!avail_zero) begin
                    rd_req_o = 1'b1;
                    take     = 1'b1;
                    d.st     = ST_TAG_RSP;
                end
            end
            ST_TAG_RSP: begin
                d.remain = tag_qwc;
                if (tag_ref) begin
                    d.data_ptr = AW'(tag_addr);
                    d.in_ring  = 1'b0;
                    d.tag_ptr  = after_tag;
                    d.last     = 1'b1;
                end else begin
                    d.data_ptr = after_tag;
                    d.tag_ptr  = ring_wrap(after_tag + span, ring_base_i, ring_mask_i);
                    d.in_ring  = 1'b1;
                    d.last     = tag_end;
                end
                if (tie_en_i && tag_irq) begin
                    d.last  = 1'b1;
                    d.early = 1'b1;
                end
                d.st = ST_DATA;
            end
            ST_DATA: begin
                if (q.remain == '0) begin
                    if (q.last) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.st = ST_TAG;
                    end
                end else begin
                    need = q.in_ring;
                    if (!q.in_ring || !avail_zero) begin
                        rd_req_o  = 1'b1;
                        rd_addr_o = q.data_ptr;
                        take      = q.in_ring;
                        d.st      = ST_DATA_RSP;
                    end
                end
            end
            ST_DATA_RSP: begin
                d.out_data  = rd_data_i;
                d.out_valid = 1'b1;
                d.remain    = q.remain - 1'b1;
                d.data_ptr  = q.in_ring
                            ? ring_wrap(q.data_ptr + QW_STEP, ring_base_i, ring_mask_i)
                            : q.data_ptr + QW_STEP;
                d.st        = ST_OUT;
            end
            ST_OUT: begin
                if (out_ready_i) begin
                    d.out_valid = 1'b0;
                    d.st        = ST_DATA;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign out_valid_o = q.out_valid;
    assign out_data_o  = q.out_data;
    assign done_irq_o  = q.done;
    assign busy_o      = q.busy;
    assign early_end_o = q.early;
    assign next_tag_o  = q.tag_ptr;

endmodule

// File: rtl/ring_chain_dma_chk.sv
module ring_chain_dma_chk #(
    parameter int AW  = 32,
    parameter int AVW = 20
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           dep_valid_i,
    input logic [15:0]    dep_qwc_i,
    input logic           take,
    input logic           rd_req_o,
    input logic [AW-1:0]  rd_addr_o,
    input logic [AW-1:0]  ring_base_i,
    input logic [AW-1:0]  ring_mask_i,
    input logic           out_valid_o,
    input logic           out_ready_i,
    input logic [127:0]   out_data_o,
    input logic           empty_irq_o,
    input logic           done_irq_o,
    input logic           busy_o,
    input logic           waiting_o,
    input logic [AVW-1:0] avail_o
);
    assert_ring_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_o && take) |-> (((rd_addr_o - ring_base_i) & ~ring_mask_i) == '0));

    assert_take_credit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> (avail_o != '0));

    assert_avail_still_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dep_valid_i && !take) |=> $stable(avail_o));

    assert_empty_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_irq_o |-> (avail_o == '0 && waiting_o));

    assert_no_read_stalled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (waiting_o && avail_o == '0 && !dep_valid_i) |-> !take);

    assert_resume_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dep_valid_i && dep_qwc_i != '0) |=> !waiting_o);

    assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_irq_o |-> !busy_o);

    assert_irq_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({empty_irq_o, done_irq_o}));

    assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

bind ring_chain_dma ring_chain_dma_chk #(.AW(AW), .AVW(AVW)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dep_valid_i (dep_valid_i),
    .dep_qwc_i   (dep_qwc_i),
    .take        (take),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .ring_base_i (ring_base_i),
    .ring_mask_i (ring_mask_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .empty_irq_o (empty_irq_o),
    .done_irq_o  (done_irq_o),
    .busy_o      (busy_o),
    .waiting_o   (waiting_o),
    .avail_o     (avail_o)
);

// File: tb/test_ring_chain_dma.sv
module test_ring_chain_dma;
    localparam int AW  = 32;
    localparam int AVW = 20;

    logic           clk_i = 1'b0;
    logic           rst_ni = 1'b0;
    logic           start_i = 1'b0;
    logic           tie_en_i = 1'b0;
    logic [AW-1:0]  ring_base_i = 32'h400;
    logic [AW-1:0]  ring_mask_i = 32'h0FF;
    logic [AW-1:0]  first_tag_i = '0;
    logic           dep_valid_i = 1'b0;
    logic [15:0]    dep_qwc_i = '0;
    logic           rd_req_o;
    logic [AW-1:0]  rd_addr_o;
    logic [127:0]   rd_data_i = '0;
    logic           out_valid_o;
    logic           out_ready_i = 1'b0;
    logic [127:0]   out_data_o;
    logic           empty_irq_o;
    logic           done_irq_o;
    logic           busy_o;
    logic           early_end_o;
    logic           waiting_o;
    logic [AW-1:0]  next_tag_o;
    logic [AVW-1:0] avail_o;

    ring_chain_dma #(.AW(AW), .AVW(AVW)) i_ring_chain_dma (.*);

    always #10 clk_i = ~clk_i;

    logic [127:0] mem [256];
    logic [127:0] exp_q [$];
    int n_checks = 0;
    int n_fail   = 0;
    int n_empty  = 0;
    int n_done   = 0;
    int cyc      = 0;
    logic         prev_hold = 1'b0;
    logic [127:0] prev_data = '0;

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [127:0] mk_tag(input logic [2:0] kind, input logic [15:0] qwc,
                                            input logic irq, input logic [31:0] addr);
        return {64'h0, addr, irq, kind, 12'h0, qwc};
    endfunction

    function automatic int slot(input int s);
        return 64 + (s % 16);
    endfunction

    task automatic tick();
        @(negedge clk_i);
        cyc++;
        out_ready_i = (cyc % 3) != 0;
        if (prev_hold)
            chk(out_valid_o && out_data_o == prev_data, "R11 hold", out_data_o, prev_data);
        if (rd_req_o) begin
            chk(rd_addr_o[3:0] == 4'h0 &&
                ((rd_addr_o >= 32'h400 && rd_addr_o < 32'h500) ||
                 (rd_addr_o >= 32'h800 && rd_addr_o < 32'h900)),
                "R1 read address", 128'(rd_addr_o), 128'h400);
            rd_data_i = mem[rd_addr_o[11:4]];
        end
        if (out_valid_o && out_ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected quadword", out_data_o, 128'h0);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                chk(out_data_o == e, "R11 stream order", out_data_o, e);
            end
        end
        prev_hold = out_valid_o && !out_ready_i;
        prev_data = out_data_o;
        if (empty_irq_o) n_empty++;
        if (done_irq_o) begin
            n_done++;
            chk(!busy_o, "R10 busy falls with done", 128'(busy_o), 128'h0);
        end
    endtask

    task automatic deposit(input logic [15:0] n);
        dep_valid_i = 1'b1;
        dep_qwc_i   = n;
        tick();
        dep_valid_i = 1'b0;
        dep_qwc_i   = '0;
    endtask

    task automatic kick(input logic [AW-1:0] a);
        first_tag_i = a;
        start_i     = 1'b1;
        tick();
        start_i     = 1'b0;
    endtask

    task automatic wait_done(input int target, input string req);
        for (int i = 0; i < 400 && n_done < target; i++) tick();
        chk(n_done == target, req, 128'(n_done), 128'(target));
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {32'hC0DE0000 + 32'(i), 96'h5A5A};
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        tick();
        // R13 reset state
        chk(!busy_o && !out_valid_o && !rd_req_o && !waiting_o && !empty_irq_o &&
            !done_irq_o && !early_end_o && avail_o == '0, "R13 reset state",
            {busy_o, out_valid_o, rd_req_o, waiting_o, early_end_o}, 128'h0);

        // A: count, odd type with zero count, end; start address wraps (R1 R2 R3 R4 R12)
        mem[slot(0)] = mk_tag(3'd1, 16'd2, 1'b0, 32'h0);
        mem[slot(3)] = mk_tag(3'd3, 16'd0, 1'b0, 32'h0);
        mem[slot(4)] = mk_tag(3'd7, 16'd3, 1'b0, 32'h0);
        foreach (mem[i]) if (i == slot(1) || i == slot(2) || (i >= slot(5) && i <= slot(7)))
            exp_q.push_back(mem[i]);
        deposit(16'd10);
        kick(32'h3400);
        wait_done(1, "R3 chain A done");
        chk(exp_q.size() == 0, "R3 all count data sent", 128'(exp_q.size()), 128'h0);
        chk(next_tag_o == 32'h480, "R4 next tag after end data", 128'(next_tag_o), 128'h480);
        chk(avail_o == 20'd2, "R7 credit after chain A", 128'(avail_o), 128'h2);
        chk(!early_end_o && n_empty == 0, "R8 no stall in A", 128'(n_empty), 128'h0);

        // B: data and closing tag wrap past ring top (R1 R4)
        mem[slot(13)] = mk_tag(3'd1, 16'd3, 1'b0, 32'h0);
        mem[slot(1)]  = mk_tag(3'd7, 16'd2, 1'b0, 32'h0);
        exp_q.push_back(mem[slot(14)]); exp_q.push_back(mem[slot(15)]);
        exp_q.push_back(mem[slot(0)]);  exp_q.push_back(mem[slot(2)]);
        exp_q.push_back(mem[slot(3)]);
        deposit(16'd5);
        kick(32'h4D0);
        wait_done(2, "R1 chain B done");
        chk(exp_q.size() == 0, "R1 wrapped data sent", 128'(exp_q.size()), 128'h0);
        chk(next_tag_o == 32'h440, "R4 wrapped next tag", 128'(next_tag_o), 128'h440);
        chk(avail_o == '0, "R7 credit after chain B", 128'(avail_o), 128'h0);

        // C: reference-end outside ring, one credit only (R5)
        mem[slot(4)] = mk_tag(3'd0, 16'd3, 1'b0, 32'h800);
        for (int i = 128; i < 131; i++) exp_q.push_back(mem[i]);
        deposit(16'd1);
        kick(32'h440);
        wait_done(3, "R5 chain C done");
        chk(exp_q.size() == 0, "R5 referenced data sent", 128'(exp_q.size()), 128'h0);
        chk(next_tag_o == 32'h450, "R5 next tag after ref tag", 128'(next_tag_o), 128'h450);
        chk(n_empty == 0 && avail_o == '0, "R5 no credit spent on ref data", 128'(avail_o), 128'h0);

        // D: starvation at tag and mid-packet; start while busy (R8 R9 R12)
        mem[slot(5)] = mk_tag(3'd7, 16'd4, 1'b0, 32'h0);
        for (int s = 6; s < 10; s++) exp_q.push_back(mem[slot(s)]);
        kick(32'h450);
        repeat (10) tick();
        chk(n_empty == 1 && waiting_o && busy_o, "R8 single empty pulse", 128'(n_empty), 128'h1);
        chk(exp_q.size() == 4, "R8 nothing sent while empty", 128'(exp_q.size()), 128'h4);
        kick(32'h4E0);
        deposit(16'd3);
        chk(!waiting_o, "R9 deposit clears waiting", 128'(waiting_o), 128'h0);
        for (int i = 0; i < 100 && n_empty < 2; i++) tick();
        chk(n_empty == 2 && exp_q.size() == 2, "R8 second stall mid-packet",
            128'(exp_q.size()), 128'h2);
        deposit(16'd2);
        wait_done(4, "R9 chain D resumes and ends");
        chk(exp_q.size() == 0, "R9 all data after resume", 128'(exp_q.size()), 128'h0);
        chk(next_tag_o == 32'h4A0, "R12 start while busy ignored", 128'(next_tag_o), 128'h4A0);

        // E: tag interrupt enabled ends chain early (R6)
        tie_en_i = 1'b1;
        mem[slot(10)] = mk_tag(3'd1, 16'd1, 1'b1, 32'h0);
        mem[slot(12)] = mk_tag(3'd1, 16'd1, 1'b0, 32'h0);
        exp_q.push_back(mem[slot(11)]);
        deposit(16'd4);
        kick(32'h4A0);
        wait_done(5, "R6 chain E done");
        chk(early_end_o, "R6 early end flag", 128'(early_end_o), 128'h1);
        chk(next_tag_o == 32'h4C0 && avail_o == 20'd2, "R6 stops after packet",
            128'(avail_o), 128'h2);

        // F: tag interrupt bit ignored when disabled; zero-count end (R6 R4 R12)
        tie_en_i = 1'b0;
        mem[slot(12)] = mk_tag(3'd1, 16'd1, 1'b1, 32'h0);
        mem[slot(14)] = mk_tag(3'd7, 16'd0, 1'b0, 32'h0);
        exp_q.push_back(mem[slot(13)]);
        deposit(16'd1);
        kick(32'h4C0);
        wait_done(6, "R6 chain F done");
        chk(!early_end_o, "R12 early flag cleared by start", 128'(early_end_o), 128'h0);
        chk(next_tag_o == 32'h4F0, "R4 zero-count end next tag", 128'(next_tag_o), 128'h4F0);
        chk(avail_o == '0 && exp_q.size() == 0, "R7 credit after chain F", 128'(avail_o), 128'h0);

        repeat (3) tick();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule